// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Keyed Threshold

This block gathers a set of peripheral interrupt request lines and picks the one the CPU should take next. Every source has a 4-bit priority, packed four to a 16-bit priority register. Every source also has a mask bit. Software sets mask bits through one bank of write-one registers and clears them through a second bank, so no read-modify-write is needed. A threshold register, written only when the correct key byte is supplied, sets the level that a priority must exceed before its source can be accepted.

The arbitration path is purely combinational from the pending lines and the stored registers. It reports whether any source qualifies, the index of the winning source and its priority level. Registers are reached over a simple single-cycle bus with word addresses. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `pic_top`

## Requirements
- R1: After reset every source is masked (mask reads 1), every priority field reads 0, the threshold reads 0 and `irq_req` is 0 whatever `irq_pend` holds.
- R2: Priority register at word address n (n < 4) holds, in bits 4m+3:4m, the priority of source 4n+m. Bits 31:16 read as 0, and a write takes effect from the next clock edge.
- R3: Nibbles whose source index is 14 or more are unassigned. They read as 0 after any write and never cause a request.
- R4: Writing to word address 0x10+k sets the mask of source 8k+b for each 1 in data bit b, and leaves bits written 0 unchanged. Reading 0x10+k returns those mask bits, with 0 for nonexistent sources.
- R5: Writing to word address 0x20+k clears the mask of source 8k+b for each 1 in data bit b, and leaves bits written 0 unchanged. Reading 0x20+k returns 0.
- R6: The threshold at word address 0x30 takes data bits 7:4 only when data bits 31:24 equal 0xA5. Any other write leaves it unchanged. A read returns the threshold in bits 7:4 and 0 elsewhere.
- R7: A source is eligible only when it is pending, unmasked, has a nonzero priority and its priority is strictly greater than the threshold. A priority equal to the threshold does not qualify.
- R8: `irq_req` is 1 exactly when some source is eligible. `irq_idx`/`irq_lvl` then give the eligible source with the highest priority, with ties won by the lowest index. With no eligible source both read 0.
- R9: The outputs follow `irq_pend` in the same cycle, with no register on the request path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | 14 | Pending request level per source |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access, 0 otherwise |
| irq_req | output | 1 | Some source is eligible |
| irq_idx | output | 4 | Index of the winning source |
| irq_lvl | output | 4 | Priority of the winning source |

## Verification
The key overlap is a register write landing in the same cycle as a change on the pending lines. A new line may rise while its priority, its mask or the threshold is being rewritten. The bench provokes this by driving random pending patterns together with random writes on every cycle. In each cycle it judges the outputs against a reference model: the model applies the new pending pattern immediately, and applies the register write only from the following cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRI_W       = 4;
  localparam int NIB_PER_REG = 4;
  localparam int MSK_W       = 8;
  localparam int MSK_BASE    = 'h10;
  localparam int CLR_BASE    = 'h20;
  localparam int THR_ADDR    = 'h30;
  localparam logic [7:0] THR_KEY = 8'hA5;
endpackage

// File: rtl/pic_regfile.sv
module pic_regfile
  import pic_pkg::*;
#(
  parameter int NUM_SRC    = 14,
  parameter int NUM_MSKREG = 13,
  parameter int ADDR_W     = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic [NUM_SRC-1:0][PRI_W-1:0] src_pri,
  output logic [NUM_SRC-1:0]            src_msk,
  output logic [PRI_W-1:0]              thr_lvl
);
  localparam int NUM_PRIREG = (NUM_SRC + NIB_PER_REG - 1) / NIB_PER_REG;

  logic [NUM_SRC-1:0][PRI_W-1:0] pri_q, pri_d;
  logic [NUM_SRC-1:0]            msk_q, msk_d;
  logic [PRI_W-1:0]              thr_q, thr_d;
  logic                          wr_pri, wr_set, wr_clr, wr_thr;
  logic                          pri_en, msk_en, thr_en;
  int                            a_int;
  logic                          unused_wdata;

  assign unused_wdata = ^bus_wdata[23:8];
  assign a_int  = int'(bus_addr);
  assign wr_pri = bus_sel && bus_wr && (a_int < NUM_PRIREG);
  assign wr_set = bus_sel && bus_wr && (a_int >= MSK_BASE) && (a_int < MSK_BASE + NUM_MSKREG);
  assign wr_clr = bus_sel && bus_wr && (a_int >= CLR_BASE) && (a_int < CLR_BASE + NUM_MSKREG);
  assign wr_thr = bus_sel && bus_wr && (a_int == THR_ADDR);

  // next-state logic
  always_comb begin
    pri_d = pri_q;
    msk_d = msk_q;
    thr_d = thr_q;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (wr_pri && (a_int == s / NIB_PER_REG))
        pri_d[s] = bus_wdata[PRI_W*(s%NIB_PER_REG) +: PRI_W];
      if (wr_set && (a_int - MSK_BASE == s / MSK_W) && bus_wdata[s%MSK_W])
        msk_d[s] = 1'b1;
      if (wr_clr && (a_int - CLR_BASE == s / MSK_W) && bus_wdata[s%MSK_W])
        msk_d[s] = 1'b0;
    end
    if (wr_thr && (bus_wdata[31:24] == THR_KEY))
      thr_d = bus_wdata[7:4];
  end

  assign pri_en = wr_pri;
  assign msk_en = wr_set || wr_clr;
  assign thr_en = wr_thr;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      msk_q <= '1;
      thr_q <= '0;
    end else begin
      if (pri_en) pri_q <= pri_d;
      if (msk_en) msk_q <= msk_d;
      if (thr_en) thr_q <= thr_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (a_int == s / NIB_PER_REG)
          bus_rdata[PRI_W*(s%NIB_PER_REG) +: PRI_W] = pri_q[s];
        if (a_int - MSK_BASE == s / MSK_W)
          bus_rdata[s%MSK_W] = msk_q[s];
      end
      if (a_int == THR_ADDR)
        bus_rdata[7:4] = thr_q;
    end
  end

  assign src_pri = pri_q;
  assign src_msk = msk_q;
  assign thr_lvl = thr_q;

  // R4 / R5: a written 1 sets or clears the addressed mask bit by the next cycle
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_msk_chk
    a_r4_mask_set : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set && (a_int - MSK_BASE == g / MSK_W) && bus_wdata[g%MSK_W]) |=> msk_q[g]);
    a_r5_mask_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && (a_int - CLR_BASE == g / MSK_W) && bus_wdata[g%MSK_W]) |=> !msk_q[g]);
  end

  // R6: a write without the key leaves the threshold alone
  a_r6_key_guard : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr && (bus_wdata[31:24] != THR_KEY)) |=> $stable(thr_q));

  // R5: clear bank always reads zero
  a_r5_clear_reads_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (a_int >= CLR_BASE) && (a_int < CLR_BASE + NUM_MSKREG))
      |-> (bus_rdata == 32'd0));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 14,
  parameter int IDX_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            pend,
  input  logic [NUM_SRC-1:0]            msk,
  input  logic [NUM_SRC-1:0][PRI_W-1:0] pri,
  input  logic [PRI_W-1:0]              thr,
  output logic                          req,
  output logic [IDX_W-1:0]              win_idx,
  output logic [PRI_W-1:0]              win_lvl
);
  logic [NUM_SRC-1:0] elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = pend[g] && !msk[g] && (pri[g] != '0) && (pri[g] > thr);
  end

  // scan downward with >= so the lowest index keeps a tie
  always_comb begin
    req     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (elig[s] && (pri[s] >= win_lvl)) begin
        req     = 1'b1;
        win_idx = IDX_W'(s);
        win_lvl = pri[s];
      end
    end
  end

  // R7: a reported winner is pending, unmasked and above the threshold
  a_r7_winner_eligible : assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (pend[win_idx] && !msk[win_idx] && (pri[win_idx] == win_lvl) && (win_lvl > thr)));

  // R8: idle outputs are zero
  a_r8_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> ((win_idx == '0) && (win_lvl == '0)));
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int NUM_SRC    = 14,
  parameter int NUM_MSKREG = 13,
  parameter int ADDR_W     = 6,
  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_pend,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_req,
  output logic [IDX_W-1:0]   irq_idx,
  output logic [PRI_W-1:0]   irq_lvl
);
  logic                          rst_meta_q, rst_sync_n;
  logic [NUM_SRC-1:0][PRI_W-1:0] src_pri;
  logic [NUM_SRC-1:0]            src_msk;
  logic [PRI_W-1:0]              thr_lvl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pic_regfile #(
    .NUM_SRC(NUM_SRC), .NUM_MSKREG(NUM_MSKREG), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_pri(src_pri), .src_msk(src_msk), .thr_lvl(thr_lvl)
  );

  pic_arbiter #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_sync_n),
    .pend(irq_pend), .msk(src_msk), .pri(src_pri), .thr(thr_lvl),
    .req(irq_req), .win_idx(irq_idx), .win_lvl(irq_lvl)
  );

  // R1: while reset is held, every source is masked so nothing is requested
  a_r1_reset_quiet : assert property (@(posedge clk)
    (!rst_sync_n && !$isunknown(src_msk)) |-> !irq_req);
endmodule

// File: tb/test_pic_top.sv
module test_pic_top;
  localparam int NS = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] irq_pend;
  logic          bus_sel, bus_wr;
  logic [5:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq_req;
  logic [3:0]    irq_idx, irq_lvl;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [3:0] pri_m [NS];
  logic       msk_m [NS];
  logic [3:0] thr_m;

  always #2.5 clk = ~clk;

  pic_top i_pic_top (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_idx(irq_idx), .irq_lvl(irq_lvl)
  );

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    logic [31:0] r = '0;
    int ai = int'(a);
    if (ai < 4) begin
      for (int n = 0; n < 4; n++)
        if (ai*4 + n < NS) r[4*n +: 4] = pri_m[ai*4 + n];
    end else if (ai >= 'h10 && ai < 'h1D) begin
      for (int b = 0; b < 8; b++)
        if ((ai-'h10)*8 + b < NS) r[b] = msk_m[(ai-'h10)*8 + b];
    end else if (ai == 'h30) begin
      r[7:4] = thr_m;
    end
    return r;
  endfunction

  // expected {req, idx, lvl}; upward scan with strict > keeps lowest index on ties
  function automatic logic [8:0] exp_out(input logic [NS-1:0] p);
    logic       rq = 1'b0;
    logic [3:0] ix = '0;
    logic [3:0] lv = '0;
    for (int s = 0; s < NS; s++)
      if (p[s] && !msk_m[s] && pri_m[s] != 0 && pri_m[s] > thr_m && pri_m[s] > lv) begin
        rq = 1'b1; ix = 4'(s); lv = pri_m[s];
      end
    return {rq, ix, lv};
  endfunction

  task automatic model_write(input logic [5:0] a, input logic [31:0] d);
    int ai = int'(a);
    if (ai < 4) begin
      for (int n = 0; n < 4; n++)
        if (ai*4 + n < NS) pri_m[ai*4 + n] = d[4*n +: 4];
    end else if (ai >= 'h10 && ai < 'h1D) begin
      for (int b = 0; b < 8; b++)
        if ((ai-'h10)*8 + b < NS && d[b]) msk_m[(ai-'h10)*8 + b] = 1'b1;
    end else if (ai >= 'h20 && ai < 'h2D) begin
      for (int b = 0; b < 8; b++)
        if ((ai-'h20)*8 + b < NS && d[b]) msk_m[(ai-'h20)*8 + b] = 1'b0;
    end else if (ai == 'h30 && d[31:24] == 8'hA5) begin
      thr_m = d[7:4];
    end
  endtask

  task automatic check_val(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one cycle: apply at negedge, check before the edge, commit model after it
  task automatic step(input logic [NS-1:0] p, input logic s, input logic w,
                      input logic [5:0] a, input logic [31:0] d,
                      input string otag, input string rtag);
    @(negedge clk);
    irq_pend = p; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    check_val(otag, {23'd0, irq_req, irq_idx, irq_lvl}, {23'd0, exp_out(p)});
    if (s && !w) check_val(rtag, bus_rdata, exp_rd(a));
    @(posedge clk);
    if (s && w) model_write(a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] all_p;
    all_p = '1;
    for (int s = 0; s < NS; s++) begin pri_m[s] = '0; msk_m[s] = 1'b1; end
    thr_m = '0;
    rst_n = 1'b0; irq_pend = '1; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    step(all_p, 1, 0, 6'h00, 0, "R1 out", "R1 pri0");
    step(all_p, 1, 0, 6'h03, 0, "R1 out", "R1 pri3");
    step(all_p, 1, 0, 6'h10, 0, "R1 out", "R1 mask0");
    step(all_p, 1, 0, 6'h11, 0, "R1 out", "R1 mask1");
    step(all_p, 1, 0, 6'h30, 0, "R1 out", "R1 thr");

    // R2 / R3: nibble placement and unassigned nibbles
    step(all_p, 1, 1, 6'h03, 32'hFFFF_FFFF, "R3 out", "");
    step(all_p, 1, 0, 6'h03, 0, "R3 out", "R3 unassigned read");
    step(all_p, 1, 1, 6'h00, 32'h0000_4321, "R2 out", "");
    step(all_p, 1, 0, 6'h00, 0, "R2 out", "R2 readback");

    // R4 / R5: set and clear banks, zero bits ignored
    step(all_p, 1, 1, 6'h20, 32'h0000_0006, "R5 out", "");
    step(all_p, 1, 0, 6'h10, 0, "R5 out", "R5 clear effect");
    step(all_p, 1, 1, 6'h10, 32'h0000_0000, "R4 out", "");
    step(all_p, 1, 0, 6'h10, 0, "R4 out", "R4 zero write ignored");
    step(all_p, 1, 0, 6'h20, 0, "R5 out", "R5 clear reads zero");

    // R8: tie goes to lowest index, then a higher priority takes over
    step(all_p, 1, 1, 6'h00, 32'h0000_0330, "R8 out", "");
    step(all_p, 0, 0, 6'h00, 0, "R8 tie lowest index", "");
    step(all_p, 1, 1, 6'h00, 32'h0000_0530, "R8 out", "");
    step(all_p, 0, 0, 6'h00, 0, "R8 highest wins", "");

    // R6 / R7: key guard and strict threshold
    step(all_p, 1, 1, 6'h30, 32'h5A00_0050, "R6 out", "");
    step(all_p, 1, 0, 6'h30, 0, "R6 bad key ignored", "R6 thr read");
    step(all_p, 1, 1, 6'h30, 32'hA500_0050, "R6 out", "");
    step(all_p, 1, 0, 6'h30, 0, "R7 equal to threshold", "R6 thr read");
    step(all_p, 1, 1, 6'h30, 32'hA500_0040, "R6 out", "");
    step(all_p, 0, 0, 6'h00, 0, "R7 above threshold", "");

    // R9 / R7: pending changes seen the same cycle, masking removes a source
    step(14'h0002, 0, 0, 6'h00, 0, "R9 single pend below thr", "");
    step(14'h0004, 0, 0, 6'h00, 0, "R9 pend switch", "");
    step(14'h0000, 0, 0, 6'h00, 0, "R9 no pend", "");
    step(14'h0004, 1, 1, 6'h10, 32'h0000_0004, "R7 out", "");
    step(14'h0004, 0, 0, 6'h00, 0, "R7 masked source", "");

    // constrained random with concurrent pend changes and writes
    begin
      void'($urandom(32'h1234_5678));
      for (int it = 0; it < 4000; it++) begin
        logic [NS-1:0] p;
        logic [31:0]   d;
        logic [5:0]    a;
        int            op;
        p  = NS'($urandom);
        d  = $urandom;
        op = $urandom_range(0, 9);
        case (op)
          0, 1: a = 6'($urandom_range(0, 3));
          2:    a = 6'h10 + 6'($urandom_range(0, 2));
          3, 4: a = 6'h20 + 6'($urandom_range(0, 2));
          5: begin
               a = 6'h30;
               if ($urandom_range(0, 1) == 1) d[31:24] = 8'hA5;
               d[7:4] = 4'($urandom_range(0, 6));
             end
          default: a = 6'($urandom);
        endcase
        if (op <= 5)
          step(p, 1, 1, a, d, "R8 random out", "");
        else
          step(p, 1, 0, a, 0, "R8 random out", "R2 random read");
      end
    end

    @(negedge clk); bus_sel = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule